// File: doc/BRIEF.md
# Configurable Register Type Logic Cell

This block is one logic cell of a programmable array. It receives four sum-of-products terms from the array (`sum_a` to `sum_d`), a set of global control signals shared by every cell, and a static configuration word. Inside the cell is a single flip-flop. The configuration sets it up as a D, T or JK register. It also picks the flip-flop clock and decides whether sum B and sum C act as an asynchronous preset and reset.

The global type-select input can change the register between load (D) and count (T) behaviour while the design runs. This lets a loadable counter be built without extra product terms. The cell drives several data outputs at the same time. Each one independently carries the register state or one of the raw sums A, B or C. A separate output enable comes either from sum D or is tied active. The surrounding array, the pads and the programming path are outside this block, and the configuration arrives as a plain input bus.

Top module: `lcell_top`

## Requirements
- R1: With an effective kind of D, the register takes `sum_a` at the register clock edge. The kind field is `cfg[1:0]`: 00 is D, 01 is T, 10 is JK, and 11 also behaves as D.
- R2: With an effective kind of T, the register inverts when `sum_a` is 1 and holds when it is 0.
- R3: With an effective kind of JK (`sum_a` as J, `sum_b` as K): 0/0 holds, 1/0 sets, 0/1 clears and 1/1 inverts.
- R4: When `cfg[2]` is 1, `glb_t_sel` overrides the kind field. 1 selects T and 0 selects D.
- R5: `cfg[4:3]` picks the register clock: 00 or 11 is the global clock, 01 is the rising edge of `sum_c`, and 10 is the rising edge of `sum_d`. An unselected clock has no effect on the register.
- R6: The register clears at once, with no clock edge, when `glb_rst` is 1 or when `cfg[7]` is 1 and `sum_c` is 1.
- R7: The register sets at once when `glb_pre` is 1 or when `cfg[6]` is 1 and `sum_b` is 1. When a clear and a set are both requested, the clear wins.
- R8: Data output i follows `cfg[10+2i:9+2i]`: 00 is the register, 01 is `sum_a`, 10 is `sum_b`, 11 is `sum_c`. This path is combinational and each output is independent of the others.
- R9: `oe` equals `sum_d` when `cfg[8]` is 1. Otherwise `oe` is 1.
- R10: When `cfg[5]` is 1, the global clock is inverted. The register then loads on the falling edge of `glb_clk` and ignores its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| glb_clk | input | 1 | Global clock shared by all cells |
| glb_pre | input | 1 | Global asynchronous set |
| glb_rst | input | 1 | Global asynchronous clear |
| glb_t_sel | input | 1 | Run-time kind select: 1 is T, 0 is D (used when cfg[2] is 1) |
| sum_a | input | 1 | Sum term A: D, T or J input |
| sum_b | input | 1 | Sum term B: K input or local set |
| sum_c | input | 1 | Sum term C: clock or local clear |
| sum_d | input | 1 | Sum term D: clock or output enable |
| cfg | input | 13 | Static configuration word (9 + 2*N_OUT bits) |
| dout | output | 2 | Selectable data outputs (N_OUT) |
| oe | output | 1 | Output enable toward the pad cell |

## Verification
The register-behaviour properties are sampled on rising edges of `glb_clk`. They only judge cycles in which the global clock drives the register without inversion, and they treat a change of configuration between two edges as excusing the check. The set and clear properties assume that set and clear requests stay at a level across a clock edge instead of pulsing between edges. They also assume that a clear is never released while a set is still active. The random stimulus keeps to these limits. It runs with local set and clear disabled, it changes configuration only while the global clear is held across an edge, and it drives all inputs one nanosecond after the rising edge. The directed cases for the local controls and the alternative clocks run while the global-clock path is deselected.

// File: rtl/lcell_pkg.sv
`timescale 1ns/1ps
package lcell_pkg;

  typedef enum logic [1:0] {
    FF_D     = 2'b00,
    FF_T     = 2'b01,
    FF_JK    = 2'b10,
    FF_D_ALT = 2'b11
  } ff_kind_e;

  typedef enum logic [1:0] {
    CK_GLB     = 2'b00,
    CK_SUMC    = 2'b01,
    CK_SUMD    = 2'b10,
    CK_GLB_ALT = 2'b11
  } ck_src_e;

  typedef enum logic [1:0] {
    OS_Q = 2'b00,
    OS_A = 2'b01,
    OS_B = 2'b10,
    OS_C = 2'b11
  } osel_e;

  // Low part of the configuration word; the output selects sit above it.
  typedef struct packed {
    logic     oe_from_d;
    logic     c_is_reset;
    logic     b_is_preset;
    logic     glb_inv;
    ck_src_e  ck_src;
    logic     dyn_en;
    ff_kind_e kind;
  } cell_cfg_t;

  localparam int BASE_CFG_W = $bits(cell_cfg_t);
  localparam int OSEL_W     = $bits(osel_e);

  // Next register value for a given kind; x is D/T/J, y is K.
  function automatic logic ff_next(ff_kind_e k, logic x, logic y, logic q);
    case (k)
      FF_T:    return q ^ x;
      FF_JK:   return (x & ~q) | (~y & q);
      default: return x;
    endcase
  endfunction

  // Effective kind after the run-time override.
  function automatic ff_kind_e pick_kind(ff_kind_e s, logic dyn, logic t_sel);
    if (dyn) return t_sel ? FF_T : FF_D;
    if (s == FF_D_ALT) return FF_D;
    return s;
  endfunction

  function automatic logic out_pick(osel_e s, logic q, logic a, logic b, logic c);
    case (s)
      OS_Q:    return q;
      OS_A:    return a;
      OS_B:    return b;
      default: return c;
    endcase
  endfunction

endpackage

// File: rtl/lcell_ctrl.sv
`timescale 1ns/1ps
module lcell_ctrl
  import lcell_pkg::*;
(
  input  logic      glb_clk,
  input  logic      glb_pre,
  input  logic      glb_rst,
  input  logic      glb_t_sel,
  input  logic      sum_b,
  input  logic      sum_c,
  input  logic      sum_d,
  input  cell_cfg_t ccfg,
  output logic      reg_clk,
  output logic      set_any,
  output logic      clr_any,
  output ff_kind_e  eff_kind,
  output logic      oe
);

  logic gclk;

  assign gclk = glb_clk ^ ccfg.glb_inv;

  always_comb begin
    case (ccfg.ck_src)
      CK_SUMC: reg_clk = sum_c;
      CK_SUMD: reg_clk = sum_d;
      default: reg_clk = gclk;
    endcase
  end

  assign clr_any  = glb_rst | (ccfg.c_is_reset & sum_c);
  assign set_any  = glb_pre | (ccfg.b_is_preset & sum_b);
  assign eff_kind = pick_kind(ccfg.kind, ccfg.dyn_en, glb_t_sel);
  assign oe       = ccfg.oe_from_d ? sum_d : 1'b1;

endmodule

// File: rtl/lcell_ff.sv
`timescale 1ns/1ps
module lcell_ff
  import lcell_pkg::*;
(
  input  logic     reg_clk,
  input  logic     set_any,
  input  logic     clr_any,
  input  ff_kind_e eff_kind,
  input  logic     x_in,
  input  logic     y_in,
  output logic     q
);

  always_ff @(posedge reg_clk or posedge clr_any or posedge set_any) begin
    if (clr_any)      q <= 1'b0;
    else if (set_any) q <= 1'b1;
    else              q <= ff_next(eff_kind, x_in, y_in, q);
  end

endmodule

// File: rtl/lcell_omux.sv
`timescale 1ns/1ps
module lcell_omux
  import lcell_pkg::*;
#(
  parameter int N_OUT = 2,
  localparam int SEL_BITS = OSEL_W * N_OUT
) (
  input  logic                q,
  input  logic                sum_a,
  input  logic                sum_b,
  input  logic                sum_c,
  input  logic [SEL_BITS-1:0] sel,
  output logic [N_OUT-1:0]    dout
);

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    osel_e s;
    assign s       = osel_e'(sel[OSEL_W*i +: OSEL_W]);
    assign dout[i] = out_pick(s, q, sum_a, sum_b, sum_c);
  end

endmodule

// File: rtl/lcell_top.sv
`timescale 1ns/1ps
module lcell_top
  import lcell_pkg::*;
#(
  parameter int N_OUT = 2,
  localparam int CFG_W = BASE_CFG_W + OSEL_W * N_OUT
) (
  input  logic             glb_clk,
  input  logic             glb_pre,
  input  logic             glb_rst,
  input  logic             glb_t_sel,
  input  logic             sum_a,
  input  logic             sum_b,
  input  logic             sum_c,
  input  logic             sum_d,
  input  logic [CFG_W-1:0] cfg,
  output logic [N_OUT-1:0] dout,
  output logic             oe
);

  cell_cfg_t ccfg;
  logic      reg_clk;
  logic      set_any;
  logic      clr_any;
  ff_kind_e  eff_kind;
  logic      q;

  assign ccfg = cell_cfg_t'(cfg[BASE_CFG_W-1:0]);

  lcell_ctrl u_ctrl (
    .glb_clk   (glb_clk),
    .glb_pre   (glb_pre),
    .glb_rst   (glb_rst),
    .glb_t_sel (glb_t_sel),
    .sum_b     (sum_b),
    .sum_c     (sum_c),
    .sum_d     (sum_d),
    .ccfg      (ccfg),
    .reg_clk   (reg_clk),
    .set_any   (set_any),
    .clr_any   (clr_any),
    .eff_kind  (eff_kind),
    .oe        (oe)
  );

  lcell_ff u_ff (
    .reg_clk  (reg_clk),
    .set_any  (set_any),
    .clr_any  (clr_any),
    .eff_kind (eff_kind),
    .x_in     (sum_a),
    .y_in     (sum_b),
    .q        (q)
  );

  lcell_omux #(.N_OUT(N_OUT)) u_omux (
    .q     (q),
    .sum_a (sum_a),
    .sum_b (sum_b),
    .sum_c (sum_c),
    .sel   (cfg[CFG_W-1:BASE_CFG_W]),
    .dout  (dout)
  );

endmodule

// File: rtl/lcell_chk.sv
`timescale 1ns/1ps
module lcell_chk
  import lcell_pkg::*;
#(
  parameter int N_OUT = 2,
  localparam int CFG_W = BASE_CFG_W + OSEL_W * N_OUT
) (
  input logic             glb_clk,
  input logic             glb_rst,
  input logic             glb_t_sel,
  input logic             sum_a,
  input logic             sum_b,
  input logic             sum_c,
  input logic             sum_d,
  input logic [CFG_W-1:0] cfg,
  input ff_kind_e         eff_kind,
  input logic             set_any,
  input logic             clr_any,
  input logic             q,
  input logic [N_OUT-1:0] dout,
  input logic             oe
);

  cell_cfg_t base;
  logic      gclk_path;

  assign base      = cell_cfg_t'(cfg[BASE_CFG_W-1:0]);
  assign gclk_path = (base.ck_src == CK_GLB || base.ck_src == CK_GLB_ALT) && !base.glb_inv;

  assert_dload_R1: assert property (@(posedge glb_clk) disable iff (clr_any || set_any)
    (gclk_path && eff_kind == FF_D) |=> (!$stable(cfg) || q == $past(sum_a)));

  assert_toggle_R2: assert property (@(posedge glb_clk) disable iff (clr_any || set_any)
    (gclk_path && eff_kind == FF_T) |=> (!$stable(cfg) || q == ($past(q) ^ $past(sum_a))));

  assert_jkset_R3: assert property (@(posedge glb_clk) disable iff (clr_any || set_any)
    (gclk_path && eff_kind == FF_JK && sum_a && !sum_b) |=> (!$stable(cfg) || q));

  assert_jkclr_R3: assert property (@(posedge glb_clk) disable iff (clr_any || set_any)
    (gclk_path && eff_kind == FF_JK && !sum_a && sum_b) |=> (!$stable(cfg) || !q));

  assert_dyn_t_R4: assert property (@(posedge glb_clk) disable iff (glb_rst)
    (base.dyn_en && glb_t_sel) |-> eff_kind == FF_T);

  assert_dyn_d_R4: assert property (@(posedge glb_clk) disable iff (glb_rst)
    (base.dyn_en && !glb_t_sel) |-> eff_kind == FF_D);

  assert_local_clr_R6: assert property (@(posedge glb_clk) disable iff (glb_rst)
    (base.c_is_reset && sum_c) |-> !q);

  assert_set_R7: assert property (@(posedge glb_clk) disable iff (glb_rst)
    (set_any && !clr_any) |-> q);

  assert_oe_tied_R9: assert property (@(posedge glb_clk) disable iff (glb_rst)
    !base.oe_from_d |-> oe);

  assert_oe_sumd_R9: assert property (@(posedge glb_clk) disable iff (glb_rst)
    base.oe_from_d |-> oe == sum_d);

  for (genvar i = 0; i < N_OUT; i++) begin : g_chk
    osel_e s;
    assign s = osel_e'(cfg[BASE_CFG_W + OSEL_W*i +: OSEL_W]);

    assert_outq_R8: assert property (@(posedge glb_clk) disable iff (glb_rst)
      (s == OS_Q) |-> dout[i] == q);

    assert_outc_R8: assert property (@(posedge glb_clk) disable iff (glb_rst)
      (s == OS_C) |-> dout[i] == sum_c);
  end

endmodule

bind lcell_top lcell_chk #(.N_OUT(N_OUT)) u_chk (
  .glb_clk   (glb_clk),
  .glb_rst   (glb_rst),
  .glb_t_sel (glb_t_sel),
  .sum_a     (sum_a),
  .sum_b     (sum_b),
  .sum_c     (sum_c),
  .sum_d     (sum_d),
  .cfg       (cfg),
  .eff_kind  (eff_kind),
  .set_any   (set_any),
  .clr_any   (clr_any),
  .q         (q),
  .dout      (dout),
  .oe        (oe)
);

// File: tb/test_lcell_top.sv
`timescale 1ns/1ps
module test_lcell_top;

  logic        clk = 1'b0;
  logic        pre, rst, tsel, a, b, c, d;
  logic [12:0] cfg;
  logic [1:0]  dout;
  logic        oe;
  int          errs = 0;
  int          checks = 0;
  bit          done = 1'b0;
  logic        q_exp;

  always #2.5 clk = ~clk;

  lcell_top i_lcell_top (
    .glb_clk(clk), .glb_pre(pre), .glb_rst(rst), .glb_t_sel(tsel),
    .sum_a(a), .sum_b(b), .sum_c(c), .sum_d(d),
    .cfg(cfg), .dout(dout), .oe(oe)
  );

  function automatic logic [12:0] mk(logic [1:0] kind, logic dyn, logic [1:0] ck, logic inv,
                                     logic bp, logic cr, logic od, logic [1:0] s0, logic [1:0] s1);
    return {s1, s0, od, cr, bp, inv, ck, dyn, kind};
  endfunction

  function automatic logic m_next(logic [1:0] k, logic dyn, logic ts, logic xa, logic xb, logic q);
    logic [1:0] kk;
    kk = dyn ? {1'b0, ts} : k;
    if (kk == 2'b01) return xa ? ~q : q;
    if (kk == 2'b10) begin
      if (xa && xb) return ~q;
      if (xa) return 1'b1;
      if (xb) return 1'b0;
      return q;
    end
    return xa;
  endfunction

  function automatic logic m_out(logic [1:0] s, logic q, logic xa, logic xb, logic xc);
    if (s == 2'b00) return q;
    if (s == 2'b01) return xa;
    if (s == 2'b10) return xb;
    return xc;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // New configuration under a global clear held across one rising edge.
  task automatic apply(logic [12:0] nc);
    rst = 1'b1; pre = 1'b0; tsel = 1'b0;
    a = 1'b0; b = 1'b0; c = 1'b0; d = 1'b0;
    cfg = nc;
    @(posedge clk);
    #1 rst = 1'b0;
    q_exp = 1'b0;
  endtask

  task automatic dstep(string req, logic exp);
    @(posedge clk);
    #1 chk(req, dout[0], exp);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; pre = 1'b0; tsel = 1'b0;
    a = 1'b0; b = 1'b0; c = 1'b0; d = 1'b0;
    cfg = '0;
    @(posedge clk);
    #1 chk("R6 reset state", dout[0], 1'b0);
    chk("R9 oe tied after reset", oe, 1'b1);

    // JK table on the global clock
    apply(mk(2'b10, 0, 2'b00, 0, 0, 0, 0, 2'b00, 2'b01));
    a = 1; b = 0; dstep("R3 jk set", 1'b1);
    a = 0; b = 0; dstep("R3 jk hold", 1'b1);
    a = 1; b = 1; dstep("R3 jk toggle", 1'b0);
    a = 1; b = 1; dstep("R3 jk toggle back", 1'b1);
    a = 0; b = 1; dstep("R3 jk clear", 1'b0);

    // kind 11 behaves as D
    apply(mk(2'b11, 0, 2'b11, 0, 0, 0, 0, 2'b00, 2'b00));
    a = 1; dstep("R1 kind 11 load", 1'b1);
    a = 0; dstep("R1 kind 11 load zero", 1'b0);

    // run-time override of a JK kind
    apply(mk(2'b10, 1, 2'b00, 0, 0, 0, 0, 2'b00, 2'b00));
    tsel = 1; a = 1; dstep("R4 override T toggle", 1'b1);
    a = 0; dstep("R2 T hold", 1'b1);
    tsel = 0; a = 0; b = 0; dstep("R4 override D load", 1'b0);

    // inverted global clock
    apply(mk(2'b00, 0, 2'b00, 1, 0, 0, 0, 2'b00, 2'b00));
    a = 1;
    @(negedge clk);
    #0.2 chk("R10 falling edge loads", dout[0], 1'b1);
    a = 0;
    @(posedge clk);
    #0.2 chk("R10 rising edge ignored", dout[0], 1'b1);
    #1;

    // sum C as clock
    apply(mk(2'b00, 0, 2'b01, 0, 0, 0, 0, 2'b00, 2'b00));
    a = 1;
    #0.2 c = 1;
    #0.2 chk("R5 sum_c edge loads", dout[0], 1'b1);
    a = 0;
    @(posedge clk);
    #1 chk("R5 global clock ignored", dout[0], 1'b1);
    c = 0;

    // sum D as clock and output enable
    apply(mk(2'b00, 0, 2'b10, 0, 0, 0, 1, 2'b00, 2'b00));
    a = 1;
    #0.2 chk("R9 oe follows sum_d low", oe, 1'b0);
    d = 1;
    #0.2 chk("R5 sum_d edge loads", dout[0], 1'b1);
    chk("R9 oe follows sum_d high", oe, 1'b1);
    d = 0;

    // asynchronous set and clear, clock parked on sum_d
    apply(mk(2'b00, 0, 2'b10, 0, 1, 1, 0, 2'b00, 2'b11));
    #0.2 b = 1;
    #0.2 chk("R7 local set", dout[0], 1'b1);
    c = 1;
    #0.2 chk("R7 clear wins over set", dout[0], 1'b0);
    chk("R8 out1 shows sum_c", dout[1], 1'b1);
    b = 0;
    #0.2 c = 0;
    pre = 1;
    #0.2 chk("R7 global set", dout[0], 1'b1);
    pre = 0;
    #0.2 c = 1;
    #0.2 chk("R6 local clear", dout[0], 1'b0);
    c = 0;
    pre = 1;
    #0.2 pre = 0;
    #0.2 rst = 1;
    #0.2 chk("R6 global clear", dout[0], 1'b0);
    rst = 0;

    // constrained random on the global clock
    for (int blk = 0; blk < 12; blk++) begin
      logic [1:0] kind, s1;
      logic dyn, od;
      kind = 2'($urandom % 4);
      s1   = 2'($urandom % 4);
      dyn  = 1'($urandom % 2);
      od   = 1'($urandom % 2);
      apply(mk(kind, dyn, 2'b00, 0, 0, 0, od, 2'b00, s1));
      for (int i = 0; i < 40; i++) begin
        a = 1'($urandom); b = 1'($urandom); c = 1'($urandom);
        d = 1'($urandom); tsel = 1'($urandom);
        @(posedge clk);
        q_exp = m_next(kind, dyn, tsel, a, b, q_exp);
        #1;
        chk("R1 R2 R3 R4 random register", dout[0], q_exp);
        chk("R8 random out1 select", dout[1], m_out(s1, q_exp, a, b, c));
        chk("R9 random oe", oe, od ? d : 1'b1);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule